// File: doc/BRIEF.md
# Ultra DMA Write-Burst Device-Side Terminator

This block is the device-side receiver for a 16-bit parallel Ultra DMA burst in which the host writes to the device. A local start input raises the transfer request. When the host grants it by pulling its acknowledge low, the block drives its ready line low and begins taking data. It takes one word on every transition of the host strobe, rising or falling, and presents each word on a data output with a one-cycle valid flag.

When local logic raises `stop_req`, the block ends the burst from the device side. It first withdraws ready, then keeps accepting the words still in flight. After a programmable minimum delay it drops the request and does not raise it again in that burst. Once the host has signalled STOP, strobe edges are ignored. The host places its CRC on the bus, and the block captures that value when the host releases its acknowledge. It compares the value with a CRC computed locally over every accepted word.

A CRC mismatch sets a sticky error flag that covers all bursts of one command. The flag is cleared only by the command-start input. All host inputs pass through one shared synchroniser, so the data, strobe, STOP and acknowledge signals stay aligned with each other.

Top module: `udma_wr_term`

## Requirements
- R1: While `stop_req` is high and no word has been accepted in the current burst, `d_rdy_n` stays low. Termination starts only after at least one word has been taken.
- R2: Device termination starts with `d_rdy_n` going high while `d_req` is still high.
- R3: `d_req` falls no sooner than `T_RP` clock cycles after `d_rdy_n` went high.
- R4: Once `d_req` has fallen during a termination, it stays low until `burst_done` has pulsed.
- R5: Strobe transitions after ready is withdrawn are still taken as words, in order, as long as `h_halt` is low. Zero to three such words are handled. With `h_halt` high, a strobe transition (including the final return of `h_strb` to 1) produces no word.
- R6: During a burst, every transition of `h_strb`, either direction, yields exactly one `word_valid` pulse. `word_data` holds the bus value present at that transition, and words come out in arrival order.
- R7: The local CRC uses polynomial 0x1021 and is seeded to 0x4ABA at burst start. It is updated once per accepted word, taking data bit 15 first. The value on `h_bus` when `h_ack_n` rises is compared with it, and a mismatch sets `crc_err` no later than the `burst_done` pulse.
- R8: `crc_err` stays set across later bursts, including bursts with a good CRC. Only a `cmd_start` pulse clears it.
- R9: After reset, and whenever `burst_done` pulses, `d_rdy_n` is 1, `d_req` is 0 and `word_valid` is 0. `crc_err` is 0 after reset.
- R10: A `burst_go` pulse raises `d_req`. When `h_ack_n` goes low, `d_rdy_n` goes low with `d_req` still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Pulse at command start; clears `crc_err` |
| burst_go | input | 1 | Pulse requesting a new write burst |
| stop_req | input | 1 | Level: device wants the burst to end |
| h_ack_n | input | 1 | Host acknowledge, active low |
| h_halt | input | 1 | Host STOP, active high |
| h_strb | input | 1 | Host data strobe, idles high |
| h_bus | input | 16 | Host data bus (data words, then CRC) |
| d_rdy_n | output | 1 | Device ready, active low |
| d_req | output | 1 | Device DMA request, active high |
| word_data | output | 16 | Received data word |
| word_valid | output | 1 | One-cycle qualifier for `word_data` |
| burst_done | output | 1 | One-cycle pulse when the burst is closed |
| crc_err | output | 1 | Sticky CRC miscompare flag for the command |

## Verification
The bench runs bursts with different splits of words before and after ready is withdrawn: zero, one, two and three trailing words. Some splits have an odd word count, so the strobe must make a data-less return to high after STOP. This separates a design that counts that edge as a word from one that ignores it. One burst raises `stop_req` before any word arrives, which separates a design that waits for the first word from one that terminates at once. Good and corrupted CRC values, followed by a good burst and then a command start, separate a sticky error flag from a per-burst flag and from a flag that is never cleared.

// File: rtl/udma_wr_pkg.sv
// Package: shared state type, CRC constants and the CRC step function
// for the write-burst terminator. Assumes a 16-bit data bus.
package udma_wr_pkg;

    localparam int unsigned WORD_W = 16;
    localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [WORD_W-1:0] CRC_SEED = 16'h4ABA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RECV,
        ST_TERM,
        ST_WREL,
        ST_CHECK
    } term_state_t;

    // One CRC update over a full word, most significant data bit first.
    function automatic logic [WORD_W-1:0] crc16_step(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] dat
    );
        logic [WORD_W-1:0] acc;
        logic              fb;
        acc = cur;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb  = acc[WORD_W-1] ^ dat[i];
            acc = {acc[WORD_W-2:0], 1'b0} ^ ({WORD_W{fb}} & CRC_POLY);
        end
        return acc;
    endfunction

endpackage

// File: rtl/udma_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// All bits pass through the same number of stages, so a data bus that is
// stable around its strobe edge stays aligned with that strobe.
// Assumes the sender holds each value for more than STAGES+1 cycles.
module udma_sync #(
    parameter int unsigned       W       = 1,
    parameter int unsigned       STAGES  = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] q;
        if (g == 0) begin : g_first
            // Purpose: first capture stage from the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d_in;
            end
        end else begin : g_rest
            // Purpose: further stages that settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign d_out = g_stage[STAGES-1].q;

endmodule

// File: rtl/udma_crc16.sv
// Module: CRC-16 accumulator over received words. It is seeded at each
// burst start and advanced once per accepted word.
// Assumes seed and upd are never high in the same cycle.
module udma_crc16
    import udma_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              upd,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] crc
);

    // Purpose: hold the running CRC, reload the seed, or advance by one word.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CRC_SEED;
        else if (seed) crc <= CRC_SEED;
        else if (upd)  crc <= crc16_step(crc, data);
    end

endmodule

// File: rtl/udma_term_fsm.sv
// Module: burst sequencer. It raises the request, grants ready when the host
// acknowledges, and decides which strobe edges carry words. It runs the
// device-side termination (ready withdrawn, request dropped after T_RP) and
// flags when the host CRC is to be captured and checked.
// Assumes all host inputs are already synchronised and mutually aligned.
module udma_term_fsm
    import udma_wr_pkg::*;
#(
    parameter int unsigned T_RP = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        stop_req,
    input  logic        ack_n_s,
    input  logic        halt_s,
    input  logic        strb_edge,
    output term_state_t st,
    output logic        rdy_n,
    output logic        req,
    output logic        seed,
    output logic        accept,
    output logic        capture,
    output logic        done
);

    localparam int unsigned     CW     = $clog2(T_RP + 2);
    localparam logic [CW-1:0]   RP_LIM = CW'(T_RP);

    term_state_t   nxt;
    logic [CW-1:0] rp_cnt;
    logic          rp_done;
    logic          words_seen;
    logic          ack_q;
    logic          ack_rel;

    // Purpose: decode word acceptance, the seed point and the acknowledge release.
    always_comb begin
        accept  = strb_edge &&
                  ((st == ST_RECV) ||
                   (((st == ST_TERM) || (st == ST_WREL)) && !halt_s));
        seed    = (st == ST_ARM) && !ack_n_s;
        ack_rel = ack_n_s && !ack_q;
        capture = (st == ST_WREL) && ack_rel;
        rp_done = (rp_cnt >= RP_LIM);
    end

    // Purpose: next-state selection for the burst sequence.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (go)                      nxt = ST_ARM;
            ST_ARM:   if (!ack_n_s)                nxt = ST_RECV;
            ST_RECV:  if (stop_req && words_seen)  nxt = ST_TERM;
            ST_TERM:  if (rp_done)                 nxt = ST_WREL;
            ST_WREL:  if (capture)                 nxt = ST_CHECK;
            ST_CHECK:                              nxt = ST_IDLE;
            default:                               nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Purpose: delayed copy of acknowledge for release-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b1;
        else        ack_q <= ack_n_s;
    end

    // Purpose: remember whether this burst has delivered a word yet.
    always_ff @(posedge clk) begin
        if (!rst_n)                        words_seen <= 1'b0;
        else if (seed)                     words_seen <= 1'b0;
        else if (accept && st == ST_RECV)  words_seen <= 1'b1;
    end

    // Purpose: count cycles since ready was withdrawn, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rp_cnt <= '0;
        else if (st == ST_RECV)              rp_cnt <= '0;
        else if (st == ST_TERM && !rp_done)  rp_cnt <= rp_cnt + 1'b1;
    end

    // Purpose: drive the ready and request lines at state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
            req   <= 1'b0;
        end else begin
            if (st == ST_IDLE && go)             req   <= 1'b1;
            if (st == ST_TERM && rp_done)        req   <= 1'b0;
            if (st == ST_ARM && !ack_n_s)        rdy_n <= 1'b0;
            if (st == ST_RECV && nxt == ST_TERM) rdy_n <= 1'b1;
        end
    end

    // Purpose: one-cycle end-of-burst pulse, issued with the CRC verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (st == ST_CHECK);
    end

    AST_REQ_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_TERM || st == ST_WREL || st == ST_CHECK) && !req) |=> !req)
        else $error("request reasserted inside termination"); // R4

    AST_RECV_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECV) |-> (req && !rdy_n))
        else $error("receiving without ready and request"); // R10

endmodule

// File: rtl/udma_wr_term.sv
// Module: top of the Ultra DMA write-burst device-side terminator.
// It synchronises the host lines, detects strobe transitions, delivers
// words and runs the CRC. It captures the host CRC on acknowledge release
// and keeps a sticky miscompare flag per command.
// Assumes the host holds the bus stable for several cycles around each
// strobe transition and around the acknowledge release.
module udma_wr_term
    import udma_wr_pkg::*;
#(
    parameter int unsigned T_RP        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              burst_go,
    input  logic              stop_req,
    input  logic              h_ack_n,
    input  logic              h_halt,
    input  logic              h_strb,
    input  logic [WORD_W-1:0] h_bus,
    output logic              d_rdy_n,
    output logic              d_req,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              burst_done,
    output logic              crc_err
);

    localparam int unsigned        BW      = WORD_W + 3;
    localparam logic [BW-1:0]      BND_RST = {1'b0, 1'b1, 1'b1, {WORD_W{1'b0}}};
    localparam int unsigned        AW      = $clog2(T_RP + 3);
    localparam logic [AW-1:0]      AGE_MAX = AW'(T_RP + 1);

    logic [BW-1:0]     bnd_s;
    logic              halt_s;
    logic              ack_n_s;
    logic              strb_s;
    logic [WORD_W-1:0] bus_s;
    logic              strb_q;
    logic              strb_edge;
    term_state_t       st;
    logic              seed;
    logic              accept;
    logic              capture;
    logic [WORD_W-1:0] crc_loc;
    logic [WORD_W-1:0] crc_host;

    udma_sync #(
        .W       (BW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BND_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({h_halt, h_ack_n, h_strb, h_bus}),
        .d_out (bnd_s)
    );

    assign {halt_s, ack_n_s, strb_s, bus_s} = bnd_s;

    // Purpose: delayed strobe for detecting transitions in either direction.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b1;
        else        strb_q <= strb_s;
    end

    assign strb_edge = strb_s ^ strb_q;

    udma_term_fsm #(
        .T_RP (T_RP)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (burst_go),
        .stop_req  (stop_req),
        .ack_n_s   (ack_n_s),
        .halt_s    (halt_s),
        .strb_edge (strb_edge),
        .st        (st),
        .rdy_n     (d_rdy_n),
        .req       (d_req),
        .seed      (seed),
        .accept    (accept),
        .capture   (capture),
        .done      (burst_done)
    );

    udma_crc16 i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed),
        .upd   (accept),
        .data  (bus_s),
        .crc   (crc_loc)
    );

    // Purpose: register each accepted word with its one-cycle qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= accept;
            if (accept) word_data <= bus_s;
        end
    end

    // Purpose: take the host CRC from the bus when acknowledge is released.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_host <= '0;
        else if (capture) crc_host <= bus_s;
    end

    // Purpose: sticky miscompare flag, cleared only at command start.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   crc_err <= 1'b0;
        else if (cmd_start)                           crc_err <= 1'b0;
        else if (st == ST_CHECK && crc_loc != crc_host) crc_err <= 1'b1;
    end

    // Checker-side bookkeeping, kept apart from the sequencer's own counter.
    logic [AW-1:0] rdy_age;
    logic [3:0]    burst_words;

    // Purpose: cycles that ready has been withdrawn, saturating (checker only).
    always_ff @(posedge clk) begin
        if (!rst_n)                              rdy_age <= AGE_MAX;
        else if (!d_rdy_n)                       rdy_age <= '0;
        else if (rdy_age != AGE_MAX)             rdy_age <= rdy_age + 1'b1;
    end

    // Purpose: words delivered in the current burst, saturating (checker only).
    always_ff @(posedge clk) begin
        if (!rst_n)                              burst_words <= '0;
        else if (burst_done)                     burst_words <= '0;
        else if (word_valid && burst_words != 4'hF) burst_words <= burst_words + 1'b1;
    end

    AST_NO_EARLY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_rdy_n) |-> (burst_words != 4'h0 || word_valid))
        else $error("termination before any word"); // R1

    AST_REQ_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(d_req) |-> (rdy_age >= AW'(T_RP)))
        else $error("request dropped too early"); // R3

    AST_NO_WORD_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !$past(halt_s))
        else $error("word taken after STOP"); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !cmd_start) |=> crc_err)
        else $error("error flag lost without command start"); // R8

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (d_rdy_n && !d_req))
        else $error("lines not idle at burst end"); // R9

endmodule

// File: tb/test_udma_wr_term.sv
// Bench: scoreboard. The host-driver task queues each word it sends; a
// monitor pops and compares words as the design delivers them.
module test_udma_wr_term;

    localparam int unsigned T_RP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        burst_go = 1'b0;
    logic        stop_req = 1'b0;
    logic        h_ack_n = 1'b1;
    logic        h_halt = 1'b0;
    logic        h_strb = 1'b1;
    logic [15:0] h_bus = 16'h0;
    logic        d_rdy_n;
    logic        d_req;
    logic [15:0] word_data;
    logic        word_valid;
    logic        burst_done;
    logic        crc_err;

    int total = 0;
    int fails = 0;
    int rx_count = 0;
    int cyc = 0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    udma_wr_term #(.T_RP(T_RP), .SYNC_STAGES(2)) i_udma_wr_term (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .burst_go(burst_go),
        .stop_req(stop_req), .h_ack_n(h_ack_n), .h_halt(h_halt),
        .h_strb(h_strb), .h_bus(h_bus), .d_rdy_n(d_rdy_n), .d_req(d_req),
        .word_data(word_data), .word_valid(word_valid),
        .burst_done(burst_done), .crc_err(crc_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r;
        r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ w[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    // Monitor: compare each delivered word with the queue head (R6, R5).
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && word_valid) begin
            rx_count++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected word", {16'h0, word_data}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(word_data == e, "R6", "word data", {16'h0, word_data}, {16'h0, e});
            end
        end
    end

    // Timing monitor for request drop and its re-rise (R3, R4).
    int   t_rdy = 0;
    logic prev_rdy = 1'b1;
    logic prev_req = 1'b0;
    logic dropped = 1'b0;
    logic rerise = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (d_rdy_n && !prev_rdy) t_rdy = cyc;
            if (!d_req && prev_req) begin
                chk((cyc - t_rdy) >= T_RP, "R3", "ready-to-request gap",
                    32'(cyc - t_rdy), 32'(T_RP));
                dropped = 1'b1;
            end
            if (d_req && !prev_req && dropped) rerise = 1'b1;
            if (burst_done) dropped = 1'b0;
        end
        prev_rdy = d_rdy_n;
        prev_req = d_req;
    end

    task automatic send_word(input logic [15:0] d);
        exp_q.push_back(d);
        h_bus = d;
        @(negedge clk);
        h_strb = ~h_strb;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_burst(input int n_pre, input int n_post, input bit bad,
                             input bit early_stop, input bit exp_err,
                             input logic [15:0] base);
        logic [15:0] crc;
        logic [15:0] d;
        int          rx0;
        rx0 = rx_count;
        rerise = 1'b0;
        crc = 16'h4ABA;
        burst_go = 1'b1;
        @(negedge clk);
        burst_go = 1'b0;
        @(negedge clk);
        chk(d_req == 1'b1, "R10", "request after go", 32'(d_req), 32'h1);
        h_ack_n = 1'b0;
        while (d_rdy_n) @(negedge clk);
        chk(d_req == 1'b1, "R10", "request with ready", 32'(d_req), 32'h1);
        if (early_stop) begin
            stop_req = 1'b1;
            repeat (12) @(negedge clk);
            chk(d_rdy_n == 1'b0, "R1", "ready held before first word", 32'(d_rdy_n), 32'h0);
        end
        for (int i = 0; i < n_pre; i++) begin
            d = base + 16'(i) * 16'h2B47;
            crc = ref_crc(crc, d);
            send_word(d);
        end
        stop_req = 1'b1;
        while (!d_rdy_n) @(negedge clk);
        chk(d_req == 1'b1, "R2", "request high when ready withdrawn", 32'(d_req), 32'h1);
        for (int i = 0; i < n_post; i++) begin
            d = ~(base + 16'(i) * 16'h1D3B);
            crc = ref_crc(crc, d);
            send_word(d);
        end
        h_halt = 1'b1;
        repeat (3) @(negedge clk);
        if (!h_strb) h_strb = 1'b1;
        repeat (6) @(negedge clk);
        while (d_req) @(negedge clk);
        h_bus = bad ? (crc ^ 16'h0100) : crc;
        repeat (2) @(negedge clk);
        h_ack_n = 1'b1;
        while (!burst_done) @(negedge clk);
        chk(crc_err == exp_err, "R7", "crc verdict", 32'(crc_err), 32'(exp_err));
        chk(d_rdy_n == 1'b1 && d_req == 1'b0, "R9", "lines idle at done",
            {30'h0, d_rdy_n, d_req}, 32'h2);
        chk(rx_count - rx0 == n_pre + n_post, "R5", "words in burst",
            32'(rx_count - rx0), 32'(n_pre + n_post));
        chk(exp_q.size() == 0, "R6", "scoreboard drained", 32'(exp_q.size()), 32'h0);
        chk(rerise == 1'b0, "R4", "request stayed low", 32'(rerise), 32'h0);
        repeat (4) @(negedge clk);
        chk(d_req == 1'b0, "R4", "request low after done", 32'(d_req), 32'h0);
        h_halt = 1'b0;
        stop_req = 1'b0;
        h_bus = 16'h0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(d_rdy_n == 1'b1, "R9", "reset ready", 32'(d_rdy_n), 32'h1);
        chk(d_req == 1'b0, "R9", "reset request", 32'(d_req), 32'h0);
        chk(word_valid == 1'b0, "R9", "reset valid", 32'(word_valid), 32'h0);
        chk(crc_err == 1'b0, "R9", "reset error", 32'(crc_err), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Two words, no trailing words, good CRC.
        run_burst(2, 0, 1'b0, 1'b0, 1'b0, 16'h1234);
        // Odd count: three plus two trailing, data-less return edge ignored.
        run_burst(3, 2, 1'b0, 1'b0, 1'b0, 16'hA5C3);
        // Stop raised before any word; one trailing word; corrupted CRC.
        run_burst(1, 1, 1'b1, 1'b1, 1'b1, 16'h0F0F);
        // Good CRC in the same command: flag must stay set (R8).
        run_burst(4, 2, 1'b0, 1'b0, 1'b1, 16'hFFFF);
        chk(crc_err == 1'b1, "R8", "flag sticky across good burst", 32'(crc_err), 32'h1);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        chk(crc_err == 1'b0, "R8", "flag cleared by command start", 32'(crc_err), 32'h0);
        // Three trailing words, odd total, good CRC.
        run_burst(4, 3, 1'b0, 1'b0, 1'b0, 16'h8001);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule